// File: doc/BRIEF.md
# Training Sequence Receive Qualifier

This block sits on one lane of a serial link receiver, after the 10-bit decoder and the symbol aligner. It takes one decoded symbol per strobe (an 8-bit value and a control-character flag), frames 16-symbol training sets that open with the comma control character, and sorts each framed set into a first-kind or second-kind set by its six identifier symbols. It also captures the link, lane, fast-training count, rate and control fields of the set.

Link training logic only trusts a partner's parameters once the same set has been seen several times in a row. This block counts how many good sets arrive in a row with the same kind, link field and lane field. When the run reaches eight, it asserts a qualification flag and loads the set's fields into holding registers. Those registers keep their values until the next qualifying set arrives. A set whose identifier symbols are all the bitwise complement of a valid identifier is not thrown away silently: it raises a polarity-inverted flag so the lane can correct itself.

Top module: `ts_rx_qualifier`

## Requirements
- R1: A set opens with a valid symbol whose value is 0xBC and whose K flag is 1. It is made of the next 16 valid symbols including that one. Cycles with `sym_vld` low neither advance nor break a set.
- R2: A valid symbol that arrives while no set is open and that is not 0xBC with K=1 is dropped, and it clears the run (`ts_qual` goes low). The held fields are unchanged.
- R3: Symbols 10 to 15 are the identifier. All six as data (K=0) equal to 0x4A mean a first-kind set. All six equal to 0x45 mean a second-kind set (`ts_is_ts2`=1). Any mix of values, or any K=1 among them, drops the set and clears the run.
- R4: If all six identifier symbols are data 0xB5 (complement of 0x4A) or 0xBA (complement of 0x45), `pol_inv` becomes 1 and the run is cleared. A set with a normal identifier sets `pol_inv` to 0. Dropped sets leave `pol_inv` unchanged.
- R5: Good sets in a row that have the same kind, the same link symbol (value and K) and the same lane symbol (value and K) form a run. `ts_qual` asserts with the 8th set of the run and stays high while matching sets continue.
- R6: A good set whose kind, link or lane differs from the previous good set starts a new run of length one, so `ts_qual` drops.
- R7: `link_num` (symbol 1), `lane_num` (symbol 2), `nfts` (symbol 3), `rate_id` (symbol 4) and `train_ctl` (symbol 5), as well as `ts_is_ts2`, come from the most recent set that qualified. They do not change at any other time.
- R8: `loopback_req` is bit 2 and `compliance_rx` is bit 4 of the held `train_ctl`.
- R9: `pad_both` is 1 when the held link and lane symbols are both 0xF7 with K=1.
- R10: The outputs take their new values in the second clock after the edge that samples a set's 16th symbol, or the dropped symbol.
- R11: After reset, every output is 0.
- R12: Symbols 6 to 9 have no effect on framing, runs or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_vld | input | 1 | Symbol strobe |
| sym_data | input | 8 | Decoded symbol value |
| sym_k | input | 1 | Symbol is a control character |
| ts_qual | output | 1 | Eight or more matching sets in a row |
| ts_is_ts2 | output | 1 | Held set is second-kind |
| link_num | output | 8 | Held link field |
| lane_num | output | 8 | Held lane field |
| nfts | output | 8 | Held fast-training count |
| rate_id | output | 8 | Held rate field |
| train_ctl | output | 8 | Held training control field |
| loopback_req | output | 1 | Held control bit 2 |
| compliance_rx | output | 1 | Held control bit 4 |
| pad_both | output | 1 | Held link and lane are both PAD |
| pol_inv | output | 1 | Last recognised identifier was complemented |

## Verification
The bench goes after runs that are one set short of eight and checks that a design counting from zero, or counting the first set twice, does not qualify a cycle early or late. It sends a different lane or a different kind in the middle of a qualified run, to catch a key compare that ignores fields or a counter that keeps its old value. It sends a stray data symbol between sets, mixed identifiers and a control flag inside the identifier; a design that drops these silently would stay qualified. It also sends complemented identifiers, to catch a polarity flag that never clears and fields overwritten by an inverted set. Idle gaps and changing filler symbols expose framing that counts clocks instead of strobes.

// File: rtl/ts_rx_pkg.sv
package ts_rx_pkg;

   localparam int SYM_W = 8;

   localparam logic [SYM_W-1:0] COM_CODE = 8'hBC;
   localparam logic [SYM_W-1:0] PAD_CODE = 8'hF7;
   localparam logic [SYM_W-1:0] ID_KIND1 = 8'h4A;
   localparam logic [SYM_W-1:0] ID_KIND2 = 8'h45;

   localparam int POS_LINK = 1;
   localparam int POS_LANE = 2;
   localparam int POS_NFTS = 3;
   localparam int POS_RATE = 4;
   localparam int POS_CTL  = 5;

   localparam int CTL_LOOP_BIT  = 2;
   localparam int CTL_COMPL_BIT = 4;

   localparam int KEY_W = 2 * SYM_W + 3;

   typedef struct packed {
      logic             is_ts2;
      logic             inv;
      logic             link_k;
      logic [SYM_W-1:0] link;
      logic             lane_k;
      logic [SYM_W-1:0] lane;
      logic [SYM_W-1:0] nfts;
      logic [SYM_W-1:0] rate;
      logic [SYM_W-1:0] ctl;
   } ts_rec_t;

endpackage

// File: rtl/ts_rx_framer.sv
module ts_rx_framer
   import ts_rx_pkg::*;
#(
   parameter int SET_LEN    = 16,
   parameter int ID_FIRST   = 10,
   parameter int POL_DETECT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_vld,
   input  logic [SYM_W-1:0] sym_data,
   input  logic             sym_k,
   output logic             set_done,
   output logic             set_drop,
   output ts_rec_t          set_rec
);

   localparam int IDX_W = $clog2(SET_LEN);
   localparam logic [IDX_W-1:0] I_LINK  = IDX_W'(POS_LINK);
   localparam logic [IDX_W-1:0] I_LANE  = IDX_W'(POS_LANE);
   localparam logic [IDX_W-1:0] I_NFTS  = IDX_W'(POS_NFTS);
   localparam logic [IDX_W-1:0] I_RATE  = IDX_W'(POS_RATE);
   localparam logic [IDX_W-1:0] I_CTL   = IDX_W'(POS_CTL);
   localparam logic [IDX_W-1:0] I_IDREF = IDX_W'(ID_FIRST);
   localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(SET_LEN - 1);

   logic             in_set;
   logic [IDX_W-1:0] idx;
   logic             f_link_k, f_lane_k;
   logic [SYM_W-1:0] f_link, f_lane, f_nfts, f_rate, f_ctl;
   logic [SYM_W-1:0] id_ref;
   logic             id_bad;

   logic             pol_allow;
   logic             is_com;
   logic             last_sym;
   logic             id_bad_all;
   logic             cls_ok, cls_ts2, cls_inv;
   ts_rec_t          rec_next;

   generate
      if (POL_DETECT != 0) begin : g_pol_on
         assign pol_allow = 1'b1;
      end else begin : g_pol_off
         assign pol_allow = 1'b0;
      end
   endgenerate

   assign is_com     = sym_k && (sym_data == COM_CODE);
   assign last_sym   = in_set && (idx == I_LAST);
   assign id_bad_all = id_bad | sym_k | (sym_data != id_ref);

   // identifier class, evaluated with the final symbol included
   always_comb begin
      cls_ok  = 1'b0;
      cls_ts2 = 1'b0;
      cls_inv = 1'b0;
      if (!id_bad_all) begin
         if (id_ref == ID_KIND1) begin
            cls_ok = 1'b1;
         end else if (id_ref == ID_KIND2) begin
            cls_ok  = 1'b1;
            cls_ts2 = 1'b1;
         end else if (pol_allow && (id_ref == ~ID_KIND1)) begin
            cls_ok  = 1'b1;
            cls_inv = 1'b1;
         end else if (pol_allow && (id_ref == ~ID_KIND2)) begin
            cls_ok  = 1'b1;
            cls_ts2 = 1'b1;
            cls_inv = 1'b1;
         end
      end
   end

   always_comb begin
      rec_next.is_ts2 = cls_ts2;
      rec_next.inv    = cls_inv;
      rec_next.link_k = f_link_k;
      rec_next.link   = f_link;
      rec_next.lane_k = f_lane_k;
      rec_next.lane   = f_lane;
      rec_next.nfts   = f_nfts;
      rec_next.rate   = f_rate;
      rec_next.ctl    = f_ctl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_set   <= 1'b0;
         idx      <= '0;
         f_link_k <= 1'b0;
         f_lane_k <= 1'b0;
         f_link   <= '0;
         f_lane   <= '0;
         f_nfts   <= '0;
         f_rate   <= '0;
         f_ctl    <= '0;
         id_ref   <= '0;
         id_bad   <= 1'b0;
         set_done <= 1'b0;
         set_drop <= 1'b0;
         set_rec  <= '0;
      end else begin
         set_done <= 1'b0;
         set_drop <= 1'b0;
         if (sym_vld) begin
            if (!in_set) begin
               if (is_com) begin
                  in_set <= 1'b1;
                  idx    <= IDX_W'(1);
                  id_bad <= 1'b0;
               end else begin
                  set_drop <= 1'b1;
               end
            end else begin
               idx <= idx + IDX_W'(1);
               if (idx == I_LINK) begin
                  f_link   <= sym_data;
                  f_link_k <= sym_k;
               end
               if (idx == I_LANE) begin
                  f_lane   <= sym_data;
                  f_lane_k <= sym_k;
               end
               if (idx == I_NFTS) f_nfts <= sym_data;
               if (idx == I_RATE) f_rate <= sym_data;
               if (idx == I_CTL)  f_ctl  <= sym_data;
               if (idx == I_IDREF) begin
                  id_ref <= sym_data;
                  id_bad <= sym_k;
               end else if (idx > I_IDREF) begin
                  id_bad <= id_bad_all;
               end
               if (last_sym) begin
                  in_set <= 1'b0;
                  idx    <= '0;
                  if (cls_ok) begin
                     set_done <= 1'b1;
                     set_rec  <= rec_next;
                  end else begin
                     set_drop <= 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/ts_rx_runcount.sv
module ts_rx_runcount
   import ts_rx_pkg::*;
#(
   parameter int QUAL_CNT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_done,
   input  logic             set_drop,
   input  logic             set_inv,
   input  logic [KEY_W-1:0] set_key,
   output logic             run_qual,
   output logic             take
);

   localparam int CNT_W = $clog2(QUAL_CNT + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_CNT);

   logic [CNT_W-1:0] cnt, cnt_nx;
   logic [KEY_W-1:0] last_key;
   logic             same;

   assign same   = (cnt != '0) && (set_key == last_key);
   assign cnt_nx = !same ? CNT_W'(1) :
                   (cnt == CNT_TOP) ? cnt : cnt + CNT_W'(1);
   assign take   = set_done && !set_inv && (cnt_nx == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         last_key <= '0;
         run_qual <= 1'b0;
      end else if (set_drop) begin
         cnt      <= '0;
         run_qual <= 1'b0;
      end else if (set_done) begin
         if (set_inv) begin
            cnt      <= '0;
            run_qual <= 1'b0;
         end else begin
            cnt      <= cnt_nx;
            last_key <= set_key;
            run_qual <= (cnt_nx == CNT_TOP);
         end
      end
   end

endmodule

// File: rtl/ts_rx_holdregs.sv
module ts_rx_holdregs
   import ts_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             set_done,
   input  ts_rec_t          set_rec,
   output logic             h_ts2,
   output logic [SYM_W-1:0] h_link,
   output logic [SYM_W-1:0] h_lane,
   output logic [SYM_W-1:0] h_nfts,
   output logic [SYM_W-1:0] h_rate,
   output logic [SYM_W-1:0] h_ctl,
   output logic             h_pad,
   output logic             h_pol
);

   logic pad_now;
   assign pad_now = set_rec.link_k && (set_rec.link == PAD_CODE) &&
                    set_rec.lane_k && (set_rec.lane == PAD_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_ts2  <= 1'b0;
         h_link <= '0;
         h_lane <= '0;
         h_nfts <= '0;
         h_rate <= '0;
         h_ctl  <= '0;
         h_pad  <= 1'b0;
      end else if (take) begin
         h_ts2  <= set_rec.is_ts2;
         h_link <= set_rec.link;
         h_lane <= set_rec.lane;
         h_nfts <= set_rec.nfts;
         h_rate <= set_rec.rate;
         h_ctl  <= set_rec.ctl;
         h_pad  <= pad_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        h_pol <= 1'b0;
      else if (set_done) h_pol <= set_rec.inv;
   end

endmodule

// File: rtl/ts_rx_qualifier.sv
module ts_rx_qualifier
   import ts_rx_pkg::*;
#(
   parameter int SET_LEN    = 16,
   parameter int ID_FIRST   = 10,
   parameter int QUAL_CNT   = 8,
   parameter int POL_DETECT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_vld,
   input  logic [SYM_W-1:0] sym_data,
   input  logic             sym_k,
   output logic             ts_qual,
   output logic             ts_is_ts2,
   output logic [SYM_W-1:0] link_num,
   output logic [SYM_W-1:0] lane_num,
   output logic [SYM_W-1:0] nfts,
   output logic [SYM_W-1:0] rate_id,
   output logic [SYM_W-1:0] train_ctl,
   output logic             loopback_req,
   output logic             compliance_rx,
   output logic             pad_both,
   output logic             pol_inv
);

   generate
      if (ID_FIRST <= POS_CTL || ID_FIRST >= SET_LEN - 1) begin : g_bad_id
         $error("ID_FIRST must lie after the control field and before the last symbol");
      end
      if (QUAL_CNT < 1) begin : g_bad_cnt
         $error("QUAL_CNT must be at least one");
      end
   endgenerate

   logic             w_done, w_drop, w_take;
   ts_rec_t          w_rec;
   logic [KEY_W-1:0] w_key;

   assign w_key = {w_rec.is_ts2, w_rec.link_k, w_rec.link, w_rec.lane_k, w_rec.lane};

   ts_rx_framer #(
      .SET_LEN   (SET_LEN),
      .ID_FIRST  (ID_FIRST),
      .POL_DETECT(POL_DETECT)
   ) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .sym_vld (sym_vld),
      .sym_data(sym_data),
      .sym_k   (sym_k),
      .set_done(w_done),
      .set_drop(w_drop),
      .set_rec (w_rec)
   );

   ts_rx_runcount #(.QUAL_CNT(QUAL_CNT)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_done(w_done),
      .set_drop(w_drop),
      .set_inv (w_rec.inv),
      .set_key (w_key),
      .run_qual(ts_qual),
      .take    (w_take)
   );

   ts_rx_holdregs u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (w_take),
      .set_done(w_done),
      .set_rec (w_rec),
      .h_ts2   (ts_is_ts2),
      .h_link  (link_num),
      .h_lane  (lane_num),
      .h_nfts  (nfts),
      .h_rate  (rate_id),
      .h_ctl   (train_ctl),
      .h_pad   (pad_both),
      .h_pol   (pol_inv)
   );

   assign loopback_req  = train_ctl[CTL_LOOP_BIT];
   assign compliance_rx = train_ctl[CTL_COMPL_BIT];

endmodule

// File: rtl/ts_rx_qualifier_chk.sv
module ts_rx_qualifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       set_done,
   input logic       set_drop,
   input logic       ts_qual,
   input logic       pol_inv,
   input logic [7:0] link_num,
   input logic [7:0] lane_num,
   input logic [7:0] nfts,
   input logic       pad_both
);

   p_rise_after_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts_qual) |-> $past(set_done));

   p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_drop |=> !ts_qual);

   p_inv_excludes_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ts_qual && pol_inv));

   p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_num) |-> ts_qual);

   p_nfts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nfts) |-> ts_qual);

   p_pad_values_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pad_both |-> (link_num == 8'hF7 && lane_num == 8'hF7));

endmodule

bind ts_rx_qualifier ts_rx_qualifier_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .set_done(w_done),
   .set_drop(w_drop),
   .ts_qual (ts_qual),
   .pol_inv (pol_inv),
   .link_num(link_num),
   .lane_num(lane_num),
   .nfts    (nfts),
   .pad_both(pad_both)
);

// File: tb/ts_rx_qualifier_tb.sv
`timescale 1ns/1ps
module ts_rx_qualifier_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_vld = 1'b0;
   logic [7:0] sym_data = 8'h00;
   logic       sym_k = 1'b0;

   logic       ts_qual, ts_is_ts2, loopback_req, compliance_rx, pad_both, pol_inv;
   logic [7:0] link_num, lane_num, nfts, rate_id, train_ctl;

   int checks = 0;
   int fails  = 0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   ts_rx_qualifier u_dut (
      .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_data(sym_data), .sym_k(sym_k),
      .ts_qual(ts_qual), .ts_is_ts2(ts_is_ts2), .link_num(link_num), .lane_num(lane_num),
      .nfts(nfts), .rate_id(rate_id), .train_ctl(train_ctl), .loopback_req(loopback_req),
      .compliance_rx(compliance_rx), .pad_both(pad_both), .pol_inv(pol_inv)
   );

   task automatic chk(input string tag, input int act, input int ex);
      checks++;
      if (act != ex) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, ex);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      bit q; bit t2; bit [7:0] link; bit [7:0] lane; bit [7:0] nf;
      bit [7:0] rate; bit [7:0] ctl; bit pad; bit pol;
   } exp_t;

   exp_t      e, p;
   bit        pv;
   bit        busy;
   int        run;
   bit [18:0] last_key;
   bit [8:0]  sq[$];

   task eval_set();
      bit ok;
      bit [7:0] v;
      bit [18:0] key;
      ok = 1'b1;
      v  = sq[10][7:0];
      for (int i = 10; i < 16; i++)
         if (sq[i][8] || sq[i][7:0] != v) ok = 1'b0;
      p = e;
      if (ok && (v == 8'h4A || v == 8'h45)) begin
         key = {v == 8'h45, sq[1], sq[2]};
         if (run > 0 && key == last_key) run++;
         else run = 1;
         last_key = key;
         p.pol = 1'b0;
         p.q   = (run >= 8);
         if (run >= 8) begin
            p.t2 = (v == 8'h45);
            p.link = sq[1][7:0]; p.lane = sq[2][7:0];
            p.nf = sq[3][7:0]; p.rate = sq[4][7:0]; p.ctl = sq[5][7:0];
            p.pad = (sq[1] == 9'h1F7) && (sq[2] == 9'h1F7);
         end
      end else if (ok && (v == 8'hB5 || v == 8'hBA)) begin
         p.q = 1'b0; p.pol = 1'b1; run = 0;
      end else begin
         p.q = 1'b0; run = 0;
      end
      pv = 1'b1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         e = '0; p = '0; pv = 1'b0; busy = 1'b0; run = 0; sq.delete();
      end else begin
         if (pv) begin e = p; pv = 1'b0; end
         if (sym_vld) begin
            if (!busy) begin
               if (sym_k && sym_data == 8'hBC) begin
                  sq.delete(); sq.push_back({sym_k, sym_data}); busy = 1'b1;
               end else begin
                  p = e; p.q = 1'b0; run = 0; pv = 1'b1;
               end
            end else begin
               sq.push_back({sym_k, sym_data});
               if (sq.size() == 16) begin busy = 1'b0; eval_set(); end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk("R5 ts_qual vs model", ts_qual, e.q);
         chk("R7 ts_is_ts2 vs model", ts_is_ts2, e.t2);
         chk("R7 link_num vs model", link_num, e.link);
         chk("R7 lane_num vs model", lane_num, e.lane);
         chk("R7 nfts vs model", nfts, e.nf);
         chk("R7 rate_id vs model", rate_id, e.rate);
         chk("R7 train_ctl vs model", train_ctl, e.ctl);
         chk("R8 loopback_req vs model", loopback_req, e.ctl[2]);
         chk("R8 compliance_rx vs model", compliance_rx, e.ctl[4]);
         chk("R9 pad_both vs model", pad_both, e.pad);
         chk("R4 pol_inv vs model", pol_inv, e.pol);
      end
   end

   // ---------------- stimulus ----------------
   task automatic put(input bit k, input bit [7:0] d);
      @(negedge clk);
      sym_vld  = 1'b1;
      sym_k    = k;
      sym_data = d;
      @(posedge clk);
      sym_vld <= 1'b0;
   endtask

   // idm: 0 normal, 1 complemented, 2 mixed, 3 K flag in identifier
   task automatic send_set(input bit t2, input bit [7:0] lnk, input bit lk,
                           input bit [7:0] lan, input bit nk, input bit [7:0] nf,
                           input bit [7:0] rt, input bit [7:0] ct, input int idm,
                           input int gap, input bit [7:0] fill);
      bit [7:0] id;
      id = t2 ? 8'h45 : 8'h4A;
      if (idm == 1) id = ~id;
      put(1'b1, 8'hBC);
      put(lk, lnk);
      put(nk, lan);
      put(1'b0, nf);
      put(1'b0, rt);
      put(1'b0, ct);
      for (int i = 6; i < 10; i++) begin
         put(1'b0, fill + 8'(i));
         if (gap > 0) repeat (gap) @(negedge clk);
      end
      for (int i = 10; i < 16; i++) begin
         if (idm == 2 && i == 13) put(1'b0, t2 ? 8'h4A : 8'h45);
         else if (idm == 3 && i == 12) put(1'b1, id);
         else put(1'b0, id);
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 ts_qual reset", ts_qual, 0);
      chk("R11 link_num reset", link_num, 0);
      chk("R11 pol_inv reset", pol_inv, 0);
      chk("R11 pad_both reset", pad_both, 0);
      rst_n = 1'b1;
      model_on = 1'b1;

      // A: first-kind PAD run
      for (int n = 0; n < 7; n++)
         send_set(1'b0, 8'hF7, 1'b1, 8'hF7, 1'b1, 8'h20, 8'h02, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R5 seven sets not qualified", ts_qual, 0);
      send_set(1'b0, 8'hF7, 1'b1, 8'hF7, 1'b1, 8'h20, 8'h02, 8'h00, 0, 0, 8'h00);
      @(negedge clk);
      chk("R10 first cycle after last symbol", ts_qual, 0);
      @(negedge clk);
      chk("R10 second cycle after last symbol", ts_qual, 1);
      chk("R9 pad_both on PAD fields", pad_both, 1);
      chk("R7 nfts captured", nfts, 8'h20);

      // B: gaps and varying filler keep the run
      send_set(1'b0, 8'hF7, 1'b1, 8'hF7, 1'b1, 8'h28, 8'h02, 8'h00, 0, 1, 8'h5A);
      send_set(1'b0, 8'hF7, 1'b1, 8'hF7, 1'b1, 8'h30, 8'h02, 8'h00, 0, 2, 8'hA0);
      settle();
      chk("R1 idle gaps keep framing", ts_qual, 1);
      chk("R12 filler symbols ignored", ts_qual, 1);
      chk("R7 nfts from latest qualified", nfts, 8'h30);

      // C: different kind breaks the run
      send_set(1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'h11, 8'h06, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R6 kind change drops qual", ts_qual, 0);
      chk("R7 fields held after break", nfts, 8'h30);

      // D: second-kind run with control bits
      for (int n = 0; n < 8; n++)
         send_set(1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h14, 0, 0, 8'h00);
      settle();
      chk("R5 second-kind run qualified", ts_qual, 1);
      chk("R3 second-kind identifier", ts_is_ts2, 1);
      chk("R7 link captured", link_num, 8'h03);
      chk("R8 loopback bit", loopback_req, 1);
      chk("R8 compliance bit", compliance_rx, 1);
      chk("R9 pad_both low", pad_both, 0);

      // E: stray data symbol between sets
      put(1'b0, 8'h00);
      settle();
      chk("R2 stray symbol clears qual", ts_qual, 0);
      chk("R2 fields unchanged", link_num, 8'h03);

      // F: mixed identifier and K flag in identifier
      for (int n = 0; n < 8; n++)
         send_set(1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R8 loopback cleared", loopback_req, 0);
      send_set(1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h00, 2, 0, 8'h00);
      settle();
      chk("R3 mixed identifier drops", ts_qual, 0);
      for (int n = 0; n < 8; n++)
         send_set(1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h00, 0, 0, 8'h00);
      send_set(1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h00, 3, 0, 8'h00);
      settle();
      chk("R3 K flag in identifier drops", ts_qual, 0);

      // G: complemented identifier
      send_set(1'b0, 8'h03, 1'b0, 8'h01, 1'b0, 8'h99, 8'h06, 8'h00, 1, 0, 8'h00);
      settle();
      chk("R4 complemented id flags", pol_inv, 1);
      chk("R4 complemented id no qual", ts_qual, 0);
      chk("R4 complemented id keeps nfts", nfts, 8'h40);
      send_set(1'b0, 8'h03, 1'b0, 8'h01, 1'b0, 8'h40, 8'h06, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R4 normal id clears flag", pol_inv, 0);

      // H: lane change inside a qualified run
      for (int n = 0; n < 8; n++)
         send_set(1'b0, 8'h03, 1'b0, 8'h01, 1'b0, 8'h50, 8'h06, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R5 first-kind run qualified", ts_qual, 1);
      send_set(1'b0, 8'h03, 1'b0, 8'h02, 1'b0, 8'h50, 8'h06, 8'h00, 0, 0, 8'h00);
      settle();
      chk("R6 lane change drops qual", ts_qual, 0);
      chk("R6 lane held", lane_num, 8'h01);

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule